// File: doc/BRIEF.md
# Double-data-rate output register pair

This block is one output path of an I/O cell. Two single-bit storage elements sit side by side. The rise element loads `d_rise` on the rising edge of `clk`. The fall element loads `d_fall` on the falling edge, which is the same as the rising edge of the inverted clock. A clock-driven multiplexer places on `q` the element that was clocked most recently. With a 50/50 clock this gives two data bits per clock period on one pin. Tying `d_rise` high and `d_fall` low makes `q` a copy of the clock. That copy travels through the same path as data, so a forwarded clock has the same delay as the data it accompanies.

Each element is configured at elaboration time. The settings are:
- which of the two force inputs (`sr`, `rev`) it responds to;
- the value `sr` forces (`rev` always forces the opposite value);
- its power-up value.

A single parameter makes both elements synchronous or both asynchronous, so one cell never mixes the two. `ce`, `sr` and `rev` each have their own polarity parameter. The clock enable can be declared unused, in which case the elements behave as though it were always asserted. An active-low global init input, `rst_n`, loads both power-up values at once.

Top module: `ddr_out_pair`

## Requirements
- R1: When the effective clock enable is on and no force applies, the rise element takes `d_rise` at each rising edge of `clk`, and the fall element takes `d_fall` at each falling edge.
- R2: While `clk` is 1, `q` shows the rise element; while `clk` is 0, `q` shows the fall element.
- R3: With `d_rise`=1, `d_fall`=0, the enable on and no force, `q` equals `clk` from the second clock phase on.
- R4: With the effective enable off, a synchronous element keeps its value across its edge. With `CE_USED`=0 the enable counts as always on, whatever `ce` carries.
- R5: Take an element whose `SR_EN` bit is set. An active `sr` forces it to its `SR_HIGH` bit. An active `rev` on an element whose `REV_EN` bit is set forces it to the inverse of that bit.
- R6: When one active input asks for 0 and another asks for 1 on the same element, the element becomes 0.
- R7: With `SYNC_MODE`=1, forces act only at the element's own clock edge and only while the effective enable is on.
- R8: With `SYNC_MODE`=0, forces act at once, whatever the clock or the enable. If a force to 0 is released while a force to 1 is still held, the element becomes 1 at once.
- R9: `CE_INV`, `SR_INV` and `REV_INV` each invert their control input before use. When the bit is set, a 0 on the pin is the active level.
- R10: While `rst_n` is 0, the rise element holds `INIT_VAL[0]` and the fall element holds `INIT_VAL[1]`, overriding every other input. `INIT_VAL` defaults to `SR_HIGH` but can be set independently of it.
- R11: An element with neither its `SR_EN` bit nor its `REV_EN` bit set is unaffected by `sr` and `rev`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the rise element uses its rising edge, the fall element its falling edge |
| rst_n | input | 1 | Global init, active low, asynchronous; loads the power-up values |
| d_rise | input | 1 | Data for the rising-edge element |
| d_fall | input | 1 | Data for the falling-edge element |
| ce | input | 1 | Clock enable shared by both elements, polarity set by `CE_INV` |
| sr | input | 1 | Force to the configured value, polarity set by `SR_INV` |
| rev | input | 1 | Force to the opposite value, polarity set by `REV_INV` |
| q | output | 1 | Multiplexed double-rate output |

## Verification
Two cases are hard to reach from the pins. The first is a force to 0 released while a force to 1 is still held on an asynchronous element. The second is a force pulse that rises and falls between two clock edges. Random stimulus changes the pins only in the middle of a clock phase, so neither case occurs reliably at random. Directed steps therefore hold `sr` and `rev` together with the enable off, then drop only `sr`, and `q` is compared right after the change as well as after the next edge. Four instances with different configurations share the same pins, and each is compared against its own reference model at every half cycle.

// File: rtl/ddr_out_pkg.sv
package ddr_out_pkg;

  localparam int unsigned NUM_PHASE = 2;
  localparam int unsigned PH_RISE   = 0;
  localparam int unsigned PH_FALL   = 1;

  typedef enum logic {
    MODE_ASYNC = 1'b0,
    MODE_SYNC  = 1'b1
  } sr_mode_e;

  // Apply a programmable inversion to a raw control pin.
  function automatic logic apply_pol(input logic raw, input logic invert);
    return raw ^ invert;
  endfunction

endpackage

// File: rtl/ddr_ctl_cond.sv
module ddr_ctl_cond
  import ddr_out_pkg::*;
#(
  parameter bit CE_USED = 1'b1,
  parameter bit CE_INV  = 1'b0,
  parameter bit SR_INV  = 1'b0,
  parameter bit REV_INV = 1'b0
) (
  input  logic ce,
  input  logic sr,
  input  logic rev,
  output logic ce_on,
  output logic sr_on,
  output logic rev_on
);

  logic ce_pol;

  always_comb begin
    ce_pol = apply_pol(ce, CE_INV);
    // An unused enable behaves as permanently asserted.
    ce_on  = ce_pol | ~CE_USED;
    sr_on  = apply_pol(sr, SR_INV);
    rev_on = apply_pol(rev, REV_INV);
  end

endmodule

// File: rtl/ddr_force_dec.sv
module ddr_force_dec #(
  parameter bit SR_EN   = 1'b0,
  parameter bit REV_EN  = 1'b0,
  parameter bit SR_HIGH = 1'b0
) (
  input  logic sr_on,
  input  logic rev_on,
  output logic force_lo,
  output logic force_hi
);

  logic sr_act;
  logic rev_act;
  logic want_lo;
  logic want_hi;

  always_comb begin
    sr_act  = SR_EN  & sr_on;
    rev_act = REV_EN & rev_on;
  end

  // sr drives toward SR_HIGH, rev toward its complement.
  generate
    if (SR_HIGH) begin : g_sr_high
      always_comb begin
        want_hi = sr_act;
        want_lo = rev_act;
      end
    end else begin : g_sr_low
      always_comb begin
        want_hi = rev_act;
        want_lo = sr_act;
      end
    end
  endgenerate

  // Reset predominates: a pending 0 masks any pending 1.
  always_comb begin
    force_lo = want_lo;
    force_hi = want_hi & ~want_lo;
  end

endmodule

// File: rtl/ddr_store_elem.sv
module ddr_store_elem #(
  parameter bit   FALL_EDGE = 1'b0,
  parameter bit   SYNC_MODE = 1'b1,
  parameter logic INIT_VAL  = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  input  logic ce_on,
  input  logic force_lo,
  input  logic force_hi,
  output logic q
);

  logic q_r;
  logic q_nxt;

  generate
    if (SYNC_MODE) begin : g_sync
      // Forces are qualified by the enable and sampled at the edge.
      always_comb begin
        q_nxt = q_r;
        if (ce_on) begin
          if (force_lo) begin
            q_nxt = 1'b0;
          end else if (force_hi) begin
            q_nxt = 1'b1;
          end else begin
            q_nxt = d;
          end
        end
      end

      if (FALL_EDGE) begin : g_neg
        always_ff @(negedge clk or negedge rst_n) begin
          if (!rst_n) begin
            q_r <= INIT_VAL;
          end else begin
            q_r <= q_nxt;
          end
        end
      end else begin : g_pos
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            q_r <= INIT_VAL;
          end else begin
            q_r <= q_nxt;
          end
        end
      end
    end else begin : g_async
      always_comb begin
        q_nxt = q_r;
        if (ce_on) begin
          q_nxt = d;
        end
      end

      // force_hi is already masked by force_lo, so its rise on release of
      // a clear re-applies a still-held preset.
      if (FALL_EDGE) begin : g_neg
        always_ff @(negedge clk or negedge rst_n or posedge force_lo or posedge force_hi) begin
          if (!rst_n) begin
            q_r <= INIT_VAL;
          end else if (force_lo) begin
            q_r <= 1'b0;
          end else if (force_hi) begin
            q_r <= 1'b1;
          end else begin
            q_r <= q_nxt;
          end
        end
      end else begin : g_pos
        always_ff @(posedge clk or negedge rst_n or posedge force_lo or posedge force_hi) begin
          if (!rst_n) begin
            q_r <= INIT_VAL;
          end else if (force_lo) begin
            q_r <= 1'b0;
          end else if (force_hi) begin
            q_r <= 1'b1;
          end else begin
            q_r <= q_nxt;
          end
        end
      end
    end
  endgenerate

  assign q = q_r;

endmodule

// File: rtl/ddr_out_mux.sv
module ddr_out_mux (
  input  logic clk,
  input  logic q_rise,
  input  logic q_fall,
  output logic q
);

  // The element clocked last is the one whose phase is current.
  always_comb begin
    if (clk) begin
      q = q_rise;
    end else begin
      q = q_fall;
    end
  end

endmodule

// File: rtl/ddr_out_pair.sv
module ddr_out_pair
  import ddr_out_pkg::*;
#(
  parameter bit                   SYNC_MODE = 1'b1,
  parameter bit                   CE_USED   = 1'b1,
  parameter bit                   CE_INV    = 1'b0,
  parameter bit                   SR_INV    = 1'b0,
  parameter bit                   REV_INV   = 1'b0,
  parameter logic [NUM_PHASE-1:0] SR_EN     = '1,
  parameter logic [NUM_PHASE-1:0] REV_EN    = '1,
  parameter logic [NUM_PHASE-1:0] SR_HIGH   = '0,
  parameter logic [NUM_PHASE-1:0] INIT_VAL  = SR_HIGH
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_rise,
  input  logic d_fall,
  input  logic ce,
  input  logic sr,
  input  logic rev,
  output logic q
);

  logic                 ce_on;
  logic                 sr_on;
  logic                 rev_on;
  logic [NUM_PHASE-1:0] d_ph;
  logic [NUM_PHASE-1:0] force_lo;
  logic [NUM_PHASE-1:0] force_hi;
  logic [NUM_PHASE-1:0] q_ph;

  always_comb begin
    d_ph          = '0;
    d_ph[PH_RISE] = d_rise;
    d_ph[PH_FALL] = d_fall;
  end

  ddr_ctl_cond #(
    .CE_USED (CE_USED),
    .CE_INV  (CE_INV),
    .SR_INV  (SR_INV),
    .REV_INV (REV_INV)
  ) u_ctl (
    .ce     (ce),
    .sr     (sr),
    .rev    (rev),
    .ce_on  (ce_on),
    .sr_on  (sr_on),
    .rev_on (rev_on)
  );

  generate
    for (genvar p = 0; p < NUM_PHASE; p++) begin : g_ph
      ddr_force_dec #(
        .SR_EN   (SR_EN[p]),
        .REV_EN  (REV_EN[p]),
        .SR_HIGH (SR_HIGH[p])
      ) u_dec (
        .sr_on    (sr_on),
        .rev_on   (rev_on),
        .force_lo (force_lo[p]),
        .force_hi (force_hi[p])
      );

      ddr_store_elem #(
        .FALL_EDGE (p == PH_FALL),
        .SYNC_MODE (SYNC_MODE),
        .INIT_VAL  (INIT_VAL[p])
      ) u_elem (
        .clk      (clk),
        .rst_n    (rst_n),
        .d        (d_ph[p]),
        .ce_on    (ce_on),
        .force_lo (force_lo[p]),
        .force_hi (force_hi[p]),
        .q        (q_ph[p])
      );
    end
  endgenerate

  ddr_out_mux u_mux (
    .clk    (clk),
    .q_rise (q_ph[PH_RISE]),
    .q_fall (q_ph[PH_FALL]),
    .q      (q)
  );

endmodule

// File: rtl/ddr_out_pair_chk.sv
module ddr_out_pair_chk #(
  parameter bit         SYNC_MODE = 1'b1,
  parameter logic [1:0] INIT_VAL  = 2'b00
) (
  input logic       clk,
  input logic       rst_n,
  input logic       d_rise,
  input logic       d_fall,
  input logic       ce_on,
  input logic [1:0] force_lo,
  input logic [1:0] force_hi,
  input logic [1:0] q_ph
);

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_INIT_LOAD: assert (q_ph == INIT_VAL); // R10
    end
  end

  generate
    if (SYNC_MODE) begin : g_sync
      AST_RISE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_on && !force_lo[0] && !force_hi[0]) |=> (q_ph[0] == $past(d_rise))); // R1
      AST_FALL_CAPTURE: assert property (@(negedge clk) disable iff (!rst_n)
        (ce_on && !force_lo[1] && !force_hi[1]) |=> (q_ph[1] == $past(d_fall))); // R1
      AST_RISE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_on |=> $stable(q_ph[0])); // R7
      AST_FALL_HOLD: assert property (@(negedge clk) disable iff (!rst_n)
        !ce_on |=> $stable(q_ph[1])); // R4
      AST_RISE_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_on && force_lo[0]) |=> (q_ph[0] == 1'b0)); // R6
      AST_FALL_SET: assert property (@(negedge clk) disable iff (!rst_n)
        (ce_on && force_hi[1]) |=> (q_ph[1] == 1'b1)); // R5
    end else begin : g_async
      AST_RISE_ASYNC_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        force_lo[0] |-> (q_ph[0] == 1'b0)); // R8
      AST_FALL_ASYNC_CLR: assert property (@(negedge clk) disable iff (!rst_n)
        force_lo[1] |-> (q_ph[1] == 1'b0)); // R8
      AST_FALL_ASYNC_SET: assert property (@(negedge clk) disable iff (!rst_n)
        force_hi[1] |-> (q_ph[1] == 1'b1)); // R5
    end
  endgenerate

endmodule

bind ddr_out_pair ddr_out_pair_chk #(
  .SYNC_MODE (SYNC_MODE),
  .INIT_VAL  (INIT_VAL)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .d_rise   (d_rise),
  .d_fall   (d_fall),
  .ce_on    (ce_on),
  .force_lo (force_lo),
  .force_hi (force_hi),
  .q_ph     (q_ph)
);

// File: tb/test_ddr_out_pair.sv
module test_ddr_out_pair;

  typedef struct packed {
    bit       sync;
    bit       ce_used;
    bit       ce_inv;
    bit       sr_inv;
    bit       rev_inv;
    bit [1:0] sr_en;
    bit [1:0] rev_en;
    bit [1:0] sr_high;
    bit [1:0] init;
  } cfg_t;

  // 0: sync, rise set+reset, fall sync set only
  localparam cfg_t C0 = '{sync:1'b1, ce_used:1'b1, ce_inv:1'b0, sr_inv:1'b0, rev_inv:1'b0,
                          sr_en:2'b11, rev_en:2'b01, sr_high:2'b10, init:2'b10};
  // 1: async, rise clear only, fall preset+clear, init overridden
  localparam cfg_t C1 = '{sync:1'b0, ce_used:1'b1, ce_inv:1'b0, sr_inv:1'b0, rev_inv:1'b0,
                          sr_en:2'b10, rev_en:2'b11, sr_high:2'b01, init:2'b11};
  // 2: sync, all controls inverted, rise sync set only
  localparam cfg_t C2 = '{sync:1'b1, ce_used:1'b1, ce_inv:1'b1, sr_inv:1'b1, rev_inv:1'b1,
                          sr_en:2'b01, rev_en:2'b00, sr_high:2'b01, init:2'b01};
  // 3: no set/reset, enable unused
  localparam cfg_t C3 = '{sync:1'b1, ce_used:1'b0, ce_inv:1'b0, sr_inv:1'b0, rev_inv:1'b0,
                          sr_en:2'b00, rev_en:2'b00, sr_high:2'b00, init:2'b01};

  localparam int WD_CYCLES = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic d1 = 1'b0, d2 = 1'b0, ce = 1'b0, sr = 1'b0, rev = 1'b0;
  logic q_o [4];

  bit    m [4][2];
  int    n_chk = 0;
  int    n_err = 0;
  bit    done = 1'b0;
  string phase = "";
  int    fwd_cnt = 0;
  string itag [4] = '{"R1 R5 R6 R7", "R5 R6 R8", "R4 R9", "R1 R11"};

  always #4 clk = ~clk;

  ddr_out_pair #(.SYNC_MODE(C0.sync), .CE_USED(C0.ce_used), .CE_INV(C0.ce_inv),
    .SR_INV(C0.sr_inv), .REV_INV(C0.rev_inv), .SR_EN(C0.sr_en), .REV_EN(C0.rev_en),
    .SR_HIGH(C0.sr_high), .INIT_VAL(C0.init)) i_ddr_out_pair (
    .clk(clk), .rst_n(rst_n), .d_rise(d1), .d_fall(d2), .ce(ce), .sr(sr), .rev(rev), .q(q_o[0]));

  ddr_out_pair #(.SYNC_MODE(C1.sync), .CE_USED(C1.ce_used), .CE_INV(C1.ce_inv),
    .SR_INV(C1.sr_inv), .REV_INV(C1.rev_inv), .SR_EN(C1.sr_en), .REV_EN(C1.rev_en),
    .SR_HIGH(C1.sr_high), .INIT_VAL(C1.init)) i_ddr_out_pair_async (
    .clk(clk), .rst_n(rst_n), .d_rise(d1), .d_fall(d2), .ce(ce), .sr(sr), .rev(rev), .q(q_o[1]));

  ddr_out_pair #(.SYNC_MODE(C2.sync), .CE_USED(C2.ce_used), .CE_INV(C2.ce_inv),
    .SR_INV(C2.sr_inv), .REV_INV(C2.rev_inv), .SR_EN(C2.sr_en), .REV_EN(C2.rev_en),
    .SR_HIGH(C2.sr_high), .INIT_VAL(C2.init)) i_ddr_out_pair_inv (
    .clk(clk), .rst_n(rst_n), .d_rise(d1), .d_fall(d2), .ce(ce), .sr(sr), .rev(rev), .q(q_o[2]));

  ddr_out_pair #(.SYNC_MODE(C3.sync), .CE_USED(C3.ce_used), .CE_INV(C3.ce_inv),
    .SR_INV(C3.sr_inv), .REV_INV(C3.rev_inv), .SR_EN(C3.sr_en), .REV_EN(C3.rev_en),
    .SR_HIGH(C3.sr_high), .INIT_VAL(C3.init)) i_ddr_out_pair_plain (
    .clk(clk), .rst_n(rst_n), .d_rise(d1), .d_fall(d2), .ce(ce), .sr(sr), .rev(rev), .q(q_o[3]));

  function automatic cfg_t cfg_of(int i);
    case (i)
      0:       return C0;
      1:       return C1;
      2:       return C2;
      default: return C3;
    endcase
  endfunction

  // Returns {force to 1, force to 0}; a pending 0 wins (R6).
  function automatic bit [1:0] force_of(cfg_t c, int e, bit s, bit r);
    bit sa = c.sr_en[e] & (s ^ c.sr_inv);
    bit ra = c.rev_en[e] & (r ^ c.rev_inv);
    bit lo = c.sr_high[e] ? ra : sa;
    bit hi = c.sr_high[e] ? sa : ra;
    return {hi & ~lo, lo};
  endfunction

  task automatic apply_async();
    for (int i = 0; i < 4; i++) begin
      for (int e = 0; e < 2; e++) begin
        cfg_t c = cfg_of(i);
        bit [1:0] f = force_of(c, e, sr, rev);
        if (!rst_n) m[i][e] = c.init[e];
        else if (!c.sync) begin
          if (f[0]) m[i][e] = 1'b0;
          else if (f[1]) m[i][e] = 1'b1;
        end
      end
    end
  endtask

  task automatic clock_model(bit rise);
    int e = rise ? 0 : 1;
    bit dv = rise ? d1 : d2;
    for (int i = 0; i < 4; i++) begin
      cfg_t c = cfg_of(i);
      bit [1:0] f = force_of(c, e, sr, rev);
      bit ce_a = !c.ce_used | (ce ^ c.ce_inv);
      if (!rst_n) m[i][e] = c.init[e];
      else if (c.sync) begin
        if (ce_a) m[i][e] = f[0] ? 1'b0 : (f[1] ? 1'b1 : dv);
      end else begin
        if (f[0]) m[i][e] = 1'b0;
        else if (f[1]) m[i][e] = 1'b1;
        else if (ce_a) m[i][e] = dv;
      end
    end
  endtask

  task automatic check_all();
    for (int i = 0; i < 4; i++) begin
      bit exp_q = clk ? m[i][0] : m[i][1];
      string tag = !rst_n ? "R10" : {phase, " ", itag[i], " R2"};
      n_chk++;
      if (q_o[i] !== exp_q) begin
        n_err++;
        $display("FAIL %s inst=%0d t=%0t actual=%b expected=%b", tag, i, $time, q_o[i], exp_q);
      end
    end
    if (phase == "R3" && fwd_cnt >= 2) begin
      for (int i = 0; i < 4; i += 3) begin
        n_chk++;
        if (q_o[i] !== clk) begin
          n_err++;
          $display("FAIL R3 clock copy inst=%0d t=%0t actual=%b expected=%b", i, $time, q_o[i], clk);
        end
      end
    end
  endtask

  // Called mid-phase: drive, check, cross one clock edge, check.
  task automatic drive(bit r, bit a, bit b, bit c, bit s, bit v);
    rst_n = r; d1 = a; d2 = b; ce = c; sr = s; rev = v;
    apply_async();
    #1 check_all();
    @(clk);
    clock_model(clk);
    #1 check_all();
    fwd_cnt++;
    #1;
  endtask

  task automatic rand_step(bit r);
    drive(r, 1'($urandom), 1'($urandom), 1'(($urandom % 4) != 0),
          1'(($urandom % 6) == 0), 1'(($urandom % 6) == 0));
  endtask

  initial begin
    #(WD_CYCLES * 8);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0D0E));
    #1 rst_n = 1'b0;
    apply_async();
    #1;
    // R10: init overrides everything while held
    for (int k = 0; k < 8; k++) rand_step(1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    // General random traffic: R1 R2 R5 R9 R11
    for (int k = 0; k < 400; k++) rand_step(1'b1);
    // R3: clock forwarding
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    phase = "R3";
    fwd_cnt = 0;
    for (int k = 0; k < 12; k++) drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    // R4: enable off holds the synchronous elements
    phase = "R4";
    for (int k = 0; k < 8; k++) drive(1'b1, 1'($urandom), 1'($urandom), 1'b0, 1'b0, 1'b0);
    // R6: both forces together
    phase = "R6";
    for (int k = 0; k < 6; k++) drive(1'b1, 1'($urandom), 1'($urandom), 1'b1, 1'b1, 1'b1);
    // R7: synchronous forces ignored with the enable off
    phase = "R7";
    drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    // R8: async pulses with the enable off, clear released while preset held
    phase = "R8";
    for (int k = 0; k < 3; k++) begin
      drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
      drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    end
    phase = "";
    for (int k = 0; k < 200; k++) rand_step(1'b1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule